// File: doc/BRIEF.md
# I2C Master Receive Byte Sequencer

This block runs the data phase of an I2C master once the target has already been addressed for reading. It drives SCL through an open-drain enable and shifts in eight data bits from SDA, most significant bit first. Each bit is sampled at the end of an SCL high phase. It then drives the acknowledge bit, either ACK (SDA low) or NACK (SDA released), according to an acknowledge-enable bit held for software. When the byte completes, it raises an interrupt flag, posts a status code and freezes the byte in a data register. It also holds SCL low, so the bus waits for software.

Software answers with a single write strobe. The strobe loads the start-request, stop-request and acknowledge-enable bits, and it clears the flag when the flag value written is 0. The stored bits decide the next bus action: another byte, a STOP, a repeated START, or a STOP followed by a START. If the block releases SDA for NACK but finds it low while SCL is high, it reports lost arbitration and releases both lines. It can then either go idle or wait until a STOP frees the bus and issue a START.

The bus is modelled as wired-AND lines without clock stretching. One SCL half period lasts `HALF_CYC` clock cycles. After the block generates a START it parks with both lines driven low until `rx_go` starts the next byte. `rx_go` is also accepted from idle, once another agent has produced a START and holds SCL low.

Top module: `i2c_mrx_byte_seq`

## Requirements
- R1: After reset the flag reads 0, the status reads F8h, `ctl_bits` reads 000, and neither line is driven.
- R2: A byte is shifted in MSB first, one bit per SCL high phase. When the flag rises, `rx_data` holds that byte. If ACK was driven (SDA low during the ninth SCL high phase), the status is 50h.
- R3: If acknowledge-enable is 0 when the eighth bit completes, SDA is released during the ninth bit and the status is 58h.
- R4: While the flag is set with status 50h or 58h, SCL is held low. `rx_data` does not change until the flag is cleared.
- R5: Clearing the flag after status 50h starts another byte. That byte is answered according to the acknowledge-enable value at that time.
- R6: After status 58h, clearing the flag with only the stop bit set (`ctl_bits` bit 1) produces exactly one STOP (SDA rising while SCL is high). The stop bit then reads 0 and both lines are released.
- R7: After status 58h, clearing the flag with only the start bit set (`ctl_bits` bit 2) produces a repeated START (SDA falling while SCL is high) with no STOP. It pulses `start_done`, clears the start bit and leaves both lines driven low.
- R8: After status 58h, clearing the flag with both bits set produces one STOP and then one START. Both bits read 0 afterwards.
- R9: If SDA is released for NACK but sampled low while SCL is high, the flag rises with status 38h and both lines are released.
- R10: After status 38h, clearing the flag with the start bit at 0 returns the block to idle. No START is issued, even after the bus becomes free.
- R11: After status 38h, clearing the flag with the start bit at 1 issues no START while the bus is busy. The START comes after a STOP has been seen, and the start bit then reads 0.
- R12: A software write with flag value 1 leaves the flag set and the status unchanged. Only a write of 0 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Observed SCL line level |
| sda_in | input | 1 | Observed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_go | input | 1 | Starts a byte from idle or parked state |
| sw_we | input | 1 | Software write strobe for the control bits |
| sw_sta | input | 1 | Written start-request bit |
| sw_stp | input | 1 | Written stop-request bit |
| sw_aak | input | 1 | Written acknowledge-enable bit |
| sw_iflg | input | 1 | Written flag value; 0 clears the flag |
| irq_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code: 50h, 58h, 38h, or F8h when no code has been posted |
| rx_data | output | 8 | Last received byte |
| ctl_bits | output | 3 | Read-back of {start, stop, acknowledge-enable} |
| start_done | output | 1 | One-cycle pulse when a generated START completes |

## Verification
The flag rises `HALF_CYC` cycles after the ninth SCL rising edge. A software write takes effect on the bus two cycles after its strobe, and each later bus event follows in whole half periods. The bench waits on the flag's rising edge and compares it at the next falling clock edge. For STOP and START sequences it waits a fixed window of several half periods that is longer than the longest sequence (six half periods plus two cycles). It then compares START and STOP counts, which are taken from the line levels on falling clock edges, where no line is moving. Negative checks (no START while busy, no START after a plain clear) look at the same counters after the same kind of window.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_PARK, S_RX_LO, S_RX_HI, S_ACK_LO, S_ACK_HI, S_HOLD, S_LOST,
        S_STP_LO, S_STP_HI, S_STP_END, S_RS_LO, S_RS_HI, S_STA_EDGE, S_STA_END,
        S_WAIT_FREE
    } seq_state_e;

    localparam logic [7:0] ST_ACKED    = 8'h50;
    localparam logic [7:0] ST_NACKED   = 8'h58;
    localparam logic [7:0] ST_ARB_LOST = 8'h38;
    localparam logic [7:0] ST_NONE     = 8'hF8;

    typedef struct packed {
        seq_state_e state;
        logic [2:0] bitn;
        logic [7:0] shift;
        logic [7:0] rdata;
        logic [7:0] status;
        logic       flag;
        logic       sta;
        logic       stp;
        logic       aak;
        logic       ackd;
    } seq_regs_t;

endpackage

// File: rtl/i2c_mrx_phase_timer.sv
module i2c_mrx_phase_timer #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(HALF - 1));

    always_comb begin
        if (restart || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_mrx_bus_watch.sv
module i2c_mrx_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_free
);
    logic scl_q, sda_q, free_q;
    logic free_d, start_seen, stop_seen;

    assign start_seen = scl_q && scl_in && sda_q && !sda_in;
    assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;

    always_comb begin
        free_d = free_q;
        if (start_seen) free_d = 1'b0;
        if (stop_seen)  free_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            free_q <= 1'b1;
        end else begin
            scl_q  <= scl_in;
            sda_q  <= sda_in;
            free_q <= free_d;
        end
    end

    assign bus_free = free_q;
endmodule

// File: rtl/i2c_mrx_byte_seq.sv
module i2c_mrx_byte_seq
    import i2c_mrx_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       rx_go,
    input  logic       sw_we,
    input  logic       sw_sta,
    input  logic       sw_stp,
    input  logic       sw_aak,
    input  logic       sw_iflg,
    output logic       irq_flag,
    output logic [7:0] status,
    output logic [7:0] rx_data,
    output logic [2:0] ctl_bits,
    output logic       start_done
);
    seq_regs_t r_d, r_q;
    logic tick, bus_free, restart;

    assign restart = (r_d.state != r_q.state);

    i2c_mrx_phase_timer #(.HALF(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    i2c_mrx_bus_watch u_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .bus_free(bus_free)
    );

    always_comb begin
        r_d        = r_q;
        scl_oe     = 1'b0;
        sda_oe     = 1'b0;
        start_done = 1'b0;

        if (sw_we) begin
            r_d.sta = sw_sta;
            r_d.stp = sw_stp;
            r_d.aak = sw_aak;
            if (!sw_iflg) r_d.flag = 1'b0;
        end

        case (r_q.state)
            S_IDLE: begin
                if (rx_go) begin
                    r_d.state = S_RX_LO;
                    r_d.bitn  = 3'd0;
                end
            end
            S_PARK: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
                if (rx_go) begin
                    r_d.state = S_RX_LO;
                    r_d.bitn  = 3'd0;
                end
            end
            S_RX_LO: begin
                scl_oe = 1'b1;
                if (tick) r_d.state = S_RX_HI;
            end
            S_RX_HI: begin
                if (tick) begin
                    r_d.shift = {r_q.shift[6:0], sda_in};
                    if (r_q.bitn == 3'd7) begin
                        r_d.state = S_ACK_LO;
                        r_d.ackd  = r_q.aak;
                    end else begin
                        r_d.state = S_RX_LO;
                        r_d.bitn  = r_q.bitn + 3'd1;
                    end
                end
            end
            S_ACK_LO: begin
                scl_oe = 1'b1;
                sda_oe = r_q.ackd;
                if (tick) r_d.state = S_ACK_HI;
            end
            S_ACK_HI: begin
                sda_oe = r_q.ackd;
                if (tick) begin
                    r_d.flag = 1'b1;
                    if (!r_q.ackd && scl_in && !sda_in) begin
                        r_d.status = ST_ARB_LOST;
                        r_d.state  = S_LOST;
                    end else begin
                        r_d.status = r_q.ackd ? ST_ACKED : ST_NACKED;
                        r_d.rdata  = r_q.shift;
                        r_d.state  = S_HOLD;
                    end
                end
            end
            S_HOLD: begin
                scl_oe = 1'b1;
                if (!r_q.flag) begin
                    if (r_q.status == ST_ACKED) begin
                        r_d.state = S_RX_LO;
                        r_d.bitn  = 3'd0;
                    end else if (r_q.stp) r_d.state = S_STP_LO;
                    else if (r_q.sta)     r_d.state = S_RS_LO;
                    else                  r_d.state = S_IDLE;
                end
            end
            S_LOST: begin
                if (!r_q.flag) r_d.state = r_q.sta ? S_WAIT_FREE : S_IDLE;
            end
            S_WAIT_FREE: begin
                if (bus_free) r_d.state = S_RS_HI;
            end
            S_STP_LO: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
                if (tick) r_d.state = S_STP_HI;
            end
            S_STP_HI: begin
                sda_oe = 1'b1;
                if (tick) r_d.state = S_STP_END;
            end
            S_STP_END: begin
                if (tick) begin
                    r_d.stp   = 1'b0;
                    r_d.state = r_q.sta ? S_RS_HI : S_IDLE;
                end
            end
            S_RS_LO: begin
                scl_oe = 1'b1;
                if (tick) r_d.state = S_RS_HI;
            end
            S_RS_HI: begin
                if (tick) r_d.state = S_STA_EDGE;
            end
            S_STA_EDGE: begin
                sda_oe = 1'b1;
                if (tick) r_d.state = S_STA_END;
            end
            S_STA_END: begin
                sda_oe = 1'b1;
                scl_oe = 1'b1;
                if (tick) begin
                    r_d.sta    = 1'b0;
                    start_done = 1'b1;
                    r_d.state  = S_PARK;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= S_IDLE;
            r_q.status <= ST_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_flag = r_q.flag;
    assign status   = r_q.status;
    assign rx_data  = r_q.rdata;
    assign ctl_bits = {r_q.sta, r_q.stp, r_q.aak};

    AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.flag |-> (r_q.status == ST_ACKED || r_q.status == ST_NACKED || r_q.status == ST_ARB_LOST)); // R2
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.flag |=> (!r_q.flag || $stable(r_q.rdata))); // R4
    AST_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && r_q.status != ST_ARB_LOST) |-> scl_oe); // R4
    AST_LOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && r_q.status == ST_ARB_LOST) |-> (!scl_oe && !sda_oe)); // R9
    AST_STP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(r_q.stp) && !$past(sw_we)) |-> ($past(r_q.state) == S_STP_END)); // R6
    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_RS_HI && $past(r_q.state) == S_WAIT_FREE) |-> $past(bus_free)); // R11
endmodule

// File: tb/sim_i2c_mrx_byte_seq.sv
`timescale 1ns/100ps
module sim_i2c_mrx_byte_seq;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic scl_oe, sda_oe, scl_w, sda_w;
    assign scl_w = !(scl_oe || tb_scl_low);
    assign sda_w = !(sda_oe || tb_sda_low);

    logic rx_go = 0, sw_we = 0, sw_sta = 0, sw_stp = 0, sw_aak = 0, sw_iflg = 0;
    logic irq_flag, start_done;
    logic [7:0] status, rx_data;
    logic [2:0] ctl_bits;

    i2c_mrx_byte_seq #(.HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_w), .sda_in(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_go(rx_go),
        .sw_we(sw_we), .sw_sta(sw_sta), .sw_stp(sw_stp), .sw_aak(sw_aak), .sw_iflg(sw_iflg),
        .irq_flag(irq_flag), .status(status), .rx_data(rx_data),
        .ctl_bits(ctl_bits), .start_done(start_done)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus event counters, sampled where no line moves
    int n_start = 0, n_stop = 0, n_sdone = 0;
    logic pscl = 1'b1, psda = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pscl && scl_w && psda && !sda_w) n_start++;
            if (pscl && scl_w && !psda && sda_w) n_stop++;
            if (start_done) n_sdone++;
        end
        pscl = scl_w;
        psda = sda_w;
    end

    // scoreboard
    typedef struct packed { logic [7:0] data; logic [7:0] code; logic ack_low; } exp_t;
    exp_t sbq[$];
    exp_t e;
    logic seen_ack_low = 1'b0;

    task automatic expect_byte(input logic [7:0] d, input logic aak, input logic pull);
        exp_t x;
        x.data    = d;
        x.code    = pull ? 8'h38 : (aak ? 8'h50 : 8'h58);
        x.ack_low = aak | pull;
        sbq.push_back(x);
    endtask

    initial begin
        forever begin
            @(posedge irq_flag);
            @(negedge clk);
            if (sbq.size() == 0) begin
                check(1'b0, "R2 unexpected flag", 32'(status), 32'h0);
            end else begin
                e = sbq.pop_front();
                if (e.code == 8'h50)      check(status == e.code, "R2 status ACK", 32'(status), 32'(e.code));
                else if (e.code == 8'h58) check(status == e.code, "R3 status NACK", 32'(status), 32'(e.code));
                else                      check(status == e.code, "R9 status lost", 32'(status), 32'(e.code));
                if (e.code != 8'h38) begin
                    check(rx_data == e.data, "R2 rx_data", 32'(rx_data), 32'(e.data));
                    check(scl_w == 1'b0, "R4 SCL held low", 32'(scl_w), 32'h0);
                end else begin
                    check(scl_w == 1'b1, "R9 SCL released", 32'(scl_w), 32'h1);
                end
                check(seen_ack_low == e.ack_low, "R3 ack bit level", 32'(seen_ack_low), 32'(e.ack_low));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_write(input logic sta, input logic stp, input logic aak, input logic iflg);
        @(negedge clk);
        sw_sta = sta; sw_stp = stp; sw_aak = aak; sw_iflg = iflg; sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic go_pulse();
        @(negedge clk); rx_go = 1'b1;
        @(negedge clk); rx_go = 1'b0;
    endtask

    task automatic slave_byte(input logic [7:0] b, input logic pull);
        tb_sda_low = !b[7];
        for (int i = 6; i >= 0; i--) begin
            @(negedge scl_w); #1 tb_sda_low = !b[i];
        end
        @(negedge scl_w); #1 tb_sda_low = pull;
        @(posedge scl_w); #1 seen_ack_low = !sda_w;
    endtask

    task automatic bench_start();
        tb_sda_low = 1'b1; wait_clk(2);
        tb_scl_low = 1'b1; wait_clk(2);
    endtask

    int s0, a0, d0;
    logic [7:0] snap;

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check(irq_flag == 1'b0, "R1 flag", 32'(irq_flag), 32'h0);
        check(status == 8'hF8, "R1 status", 32'(status), 32'hF8);
        check(ctl_bits == 3'b000, "R1 ctl_bits", 32'(ctl_bits), 32'h0);
        check(scl_w && sda_w, "R1 lines released", 32'({scl_w, sda_w}), 32'h3);

        // byte with ACK
        sw_write(1'b0, 1'b0, 1'b1, 1'b1);
        bench_start();
        expect_byte(8'hA5, 1'b1, 1'b0);
        fork
            begin go_pulse(); wait_clk(1); tb_scl_low = 1'b0; end
            slave_byte(8'hA5, 1'b0);
        join
        wait (irq_flag == 1'b1);
        wait_clk(3);
        snap = rx_data;
        wait_clk(4 * HALF);
        check(scl_w == 1'b0, "R4 SCL still low", 32'(scl_w), 32'h0);
        check(rx_data == snap, "R4 data stable", 32'(rx_data), 32'(snap));
        // R12 write of flag value 1
        sw_write(1'b0, 1'b0, 1'b1, 1'b1);
        wait_clk(2);
        check(irq_flag == 1'b1, "R12 flag kept", 32'(irq_flag), 32'h1);
        check(status == 8'h50, "R12 status kept", 32'(status), 32'h50);

        // R5 next byte after 50h, now with NACK
        expect_byte(8'h3C, 1'b0, 1'b0);
        fork
            sw_write(1'b0, 1'b0, 1'b0, 1'b0);
            slave_byte(8'h3C, 1'b0);
        join
        wait (irq_flag == 1'b1);
        wait_clk(3);
        check(status == 8'h58, "R5 second byte NACK", 32'(status), 32'h58);

        // R6 STOP
        s0 = n_stop; a0 = n_start;
        sw_write(1'b0, 1'b1, 1'b0, 1'b0);
        wait_clk(8 * HALF);
        check(n_stop == s0 + 1, "R6 one STOP", 32'(n_stop - s0), 32'h1);
        check(n_start == a0, "R6 no START", 32'(n_start - a0), 32'h0);
        check(ctl_bits[1] == 1'b0, "R6 stop bit cleared", 32'(ctl_bits), 32'h0);
        check(scl_w && sda_w, "R6 lines released", 32'({scl_w, sda_w}), 32'h3);

        // R7 repeated START
        bench_start();
        expect_byte(8'h81, 1'b0, 1'b0);
        fork
            begin go_pulse(); wait_clk(1); tb_scl_low = 1'b0; end
            slave_byte(8'h81, 1'b0);
        join
        wait (irq_flag == 1'b1);
        wait_clk(3);
        s0 = n_stop; a0 = n_start; d0 = n_sdone;
        sw_write(1'b1, 1'b0, 1'b0, 1'b0);
        wait_clk(8 * HALF);
        check(n_start == a0 + 1, "R7 one START", 32'(n_start - a0), 32'h1);
        check(n_stop == s0, "R7 no STOP", 32'(n_stop - s0), 32'h0);
        check(n_sdone == d0 + 1, "R7 start_done pulse", 32'(n_sdone - d0), 32'h1);
        check(ctl_bits[2] == 1'b0, "R7 start bit cleared", 32'(ctl_bits), 32'h0);
        check(!scl_w && !sda_w, "R7 parked low", 32'({scl_w, sda_w}), 32'h0);

        // R8 STOP then START
        expect_byte(8'h5A, 1'b0, 1'b0);
        fork
            go_pulse();
            slave_byte(8'h5A, 1'b0);
        join
        wait (irq_flag == 1'b1);
        wait_clk(3);
        s0 = n_stop; a0 = n_start;
        sw_write(1'b1, 1'b1, 1'b0, 1'b0);
        wait_clk(12 * HALF);
        check(n_stop == s0 + 1, "R8 one STOP", 32'(n_stop - s0), 32'h1);
        check(n_start == a0 + 1, "R8 one START", 32'(n_start - a0), 32'h1);
        check(ctl_bits[2:1] == 2'b00, "R8 bits cleared", 32'(ctl_bits), 32'h0);

        // R9 arbitration lost, then R10 plain clear
        expect_byte(8'hC3, 1'b0, 1'b1);
        fork
            go_pulse();
            slave_byte(8'hC3, 1'b1);
        join
        wait (irq_flag == 1'b1);
        wait_clk(3);
        a0 = n_start;
        sw_write(1'b0, 1'b0, 1'b0, 1'b0);
        wait_clk(2);
        tb_sda_low = 1'b0;
        wait_clk(8 * HALF);
        check(n_start == a0, "R10 no START", 32'(n_start - a0), 32'h0);
        check(scl_w && sda_w, "R10 idle lines", 32'({scl_w, sda_w}), 32'h3);
        check(irq_flag == 1'b0, "R10 flag cleared", 32'(irq_flag), 32'h0);

        // R11 arbitration lost, START once bus free
        bench_start();
        expect_byte(8'hE7, 1'b0, 1'b1);
        fork
            begin go_pulse(); wait_clk(1); tb_scl_low = 1'b0; end
            slave_byte(8'hE7, 1'b1);
        join
        wait (irq_flag == 1'b1);
        wait_clk(3);
        a0 = n_start; d0 = n_sdone;
        sw_write(1'b1, 1'b0, 1'b0, 1'b0);
        wait_clk(8 * HALF);
        check(n_start == a0, "R11 no START while busy", 32'(n_start - a0), 32'h0);
        check(ctl_bits[2] == 1'b1, "R11 start bit pending", 32'(ctl_bits), 32'h4);
        tb_sda_low = 1'b0;
        wait_clk(8 * HALF);
        check(n_start == a0 + 1, "R11 START after free", 32'(n_start - a0), 32'h1);
        check(n_sdone == d0 + 1, "R11 start_done pulse", 32'(n_sdone - d0), 32'h1);
        check(ctl_bits[2] == 1'b0, "R11 start bit cleared", 32'(ctl_bits), 32'h0);

        check(sbq.size() == 0, "R2 all bytes flagged", 32'(sbq.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule